// File: doc/BRIEF.md
# Interrupt Arbiter with Vector Table Fetch

This block works next to a small 16-bit segmented processor core. At every instruction boundary it looks at all the interrupt sources and picks one to service. The sources are the core's internal exception lines, a single-step trap taken from the trap flag, a non-maskable pin, a software interrupt carrying a type byte, and a maskable external pin. The external pin gets its type byte back through an acknowledge handshake. Once a request is accepted, the block reads a four-byte entry from a vector table in low memory over a 16-bit read port.

After the two table reads, the block hands the core a new code segment and instruction offset, together with the 20-bit physical address where fetching resumes. It also owns the interrupt-enable and trap flags. The core can write both flags, and the block clears both whenever it accepts a request. Stack pushes, the return path and instruction decode belong to the core.

Top module: `irq_vector_ctrl`

## Requirements
- R1: When requests from several groups are present at the same boundary, the group served is the first one present in this order: internal (exception lines and trap), non-maskable, software, external.
- R2: In the internal group, a single raised exception line with type k competes with the trap request (type 1), and the lower of the two type numbers is served.
- R3: If two or more exception lines are high at the same boundary, type 8 is served and neither of the raised types is.
- R4: A high `nmi_i` at a boundary with no internal request is served as type 2, whatever value `ie_o` holds.
- R5: When `tf_o` is 1 at a boundary and no exception line is high, type 1 is served.
- R6: On the clock edge that accepts a request, `ie_o` and `tf_o` both go to 0, and this takes priority over a core write made in the same cycle.
- R7: `intr_i` is ignored while `ie_o` is 0. No acknowledge pulse appears and `busy_o` stays 0.
- R8: Accepting the external request drives `inta_o` high for exactly one cycle, starting the cycle after acceptance. The type is taken from `intr_data_i` during the cycle that immediately follows the acknowledge cycle.
- R9: Requests are sampled only on a rising edge where `boundary_i` is 1 and `busy_o` is 0. At any other time they have no effect.
- R10: For type n, the block first reads byte address 4n, which loads the offset, and then reads 4n+2, which loads the segment. Each read holds `mem_req_o` and the address until `mem_rdy_i` is seen, and every address lies below 0x400.
- R11: After the second read, `done_o` is high for one cycle. During that cycle and the cycle after it, `new_ip_o`, `new_cs_o` and `svc_type_o` hold the results, and `fetch_addr_o` equals (16*segment + offset) mod 2^20.
- R12: While `rst` is high, `busy_o`, `done_o`, `inta_o`, `mem_req_o`, `ie_o` and `tf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| exc_req_i | input | NEXC | Exception lines; bit k requests type k |
| nmi_i | input | 1 | Non-maskable request, served as type 2 |
| swi_req_i | input | 1 | Software interrupt request |
| swi_type_i | input | 8 | Type byte of the software interrupt |
| intr_i | input | 1 | Maskable external request |
| intr_data_i | input | 8 | Type byte returned after the acknowledge |
| inta_o | output | 1 | One-cycle acknowledge of the external request |
| ie_wr_i | input | 1 | Core write strobe for the enable flag |
| ie_val_i | input | 1 | Value written to the enable flag |
| tf_wr_i | input | 1 | Core write strobe for the trap flag |
| tf_val_i | input | 1 | Value written to the trap flag |
| ie_o | output | 1 | Interrupt-enable flag |
| tf_o | output | 1 | Trap flag |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 20 | Table read byte address |
| mem_rdy_i | input | 1 | Read data valid |
| mem_data_i | input | 16 | Read data word |
| busy_o | output | 1 | A service sequence is in progress |
| done_o | output | 1 | New segment and offset are ready |
| svc_type_o | output | 8 | Type number being serviced |
| new_cs_o | output | 16 | New code segment |
| new_ip_o | output | 16 | New instruction offset |
| fetch_addr_o | output | 20 | Physical resume address |

## Verification
The hardest cases to reach from the ports are a boundary strobe that arrives while a service is already running, and an acknowledge-type capture taken one cycle too early. For the first, a second software request with its own boundary pulse is raised in the middle of a slow table read, and the bench then checks which vector was fetched and that no second service starts. For the second, the type bus carries a decoy value on every cycle except the one right after the acknowledge, so a capture on the wrong cycle fetches the wrong vector. The software type is swept over all 256 values, and exception pairs are swept to reach the type-8 case.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;
  localparam int TYPE_W = 8;

  localparam logic [TYPE_W-1:0] TYPE_TRAP = 8'd1;
  localparam logic [TYPE_W-1:0] TYPE_NMI  = 8'd2;
  localparam logic [TYPE_W-1:0] TYPE_DBL  = 8'd8;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_INT, SRC_NMI, SRC_SWI, SRC_EXT
  } irq_src_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACK, ST_CAPT, ST_RD_OFF, ST_RD_SEG, ST_DONE
  } fetch_st_t;

  // byte address of one half of the table entry for type t
  function automatic logic [ADDR_W-1:0] vec_byte_addr(input logic [TYPE_W-1:0] t,
                                                      input logic seg_half);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[TYPE_W+1:2] = t;
    a[1] = seg_half;
    return a;
  endfunction

  // physical address from segment and offset, wrapped to ADDR_W bits
  function automatic logic [ADDR_W-1:0] phys_addr(input logic [WORD_W-1:0] seg,
                                                  input logic [WORD_W-1:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction
endpackage

// File: rtl/irq_flags.sv
`timescale 1ns/1ps
module irq_flags (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic ie_wr,
  input  logic ie_val,
  input  logic tf_wr,
  input  logic tf_val,
  output logic ie,
  output logic tf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0;
      tf <= 1'b0;
    end else if (accept) begin
      ie <= 1'b0;
      tf <= 1'b0;
    end else begin
      if (ie_wr) ie <= ie_val;
      if (tf_wr) tf <= tf_val;
    end
  end

  // R6: an accepted request leaves both flags clear
  a_r6_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!ie && !tf));
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NEXC = 16
) (
  input  logic [NEXC-1:0]   exc_req,
  input  logic              trap_req,
  input  logic              nmi,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              intr,
  input  logic              ie,
  output irq_src_t          src,
  output logic [TYPE_W-1:0] sel_type,
  output logic              dbl_fault,
  output logic              any_req
);
  logic [TYPE_W-1:0] low_idx;
  logic              exc_any;
  logic              exc_wins;

  always_comb begin
    low_idx = '0;
    for (int i = NEXC - 1; i >= 0; i--) begin
      if (exc_req[i]) low_idx = TYPE_W'(i);
    end
  end

  assign exc_any   = |exc_req;
  assign dbl_fault = ($countones(exc_req) >= 2);
  assign exc_wins  = exc_any && !(trap_req && (low_idx > TYPE_TRAP));

  always_comb begin
    src      = SRC_NONE;
    sel_type = '0;
    if (dbl_fault) begin
      src      = SRC_INT;
      sel_type = TYPE_DBL;
    end else if (exc_wins) begin
      src      = SRC_INT;
      sel_type = low_idx;
    end else if (trap_req) begin
      src      = SRC_INT;
      sel_type = TYPE_TRAP;
    end else if (nmi) begin
      src      = SRC_NMI;
      sel_type = TYPE_NMI;
    end else if (swi_req) begin
      src      = SRC_SWI;
      sel_type = swi_type;
    end else if (intr && ie) begin
      src      = SRC_EXT;
      sel_type = '0;
    end
  end

  assign any_req = (src != SRC_NONE);

  // R7: the external source is never chosen while the enable flag is clear
  always_comb begin
    a_r7_masked_ext: assert (!(src == SRC_EXT && !ie));
  end
endmodule

// File: rtl/irq_vector_fetch.sv
`timescale 1ns/1ps
module irq_vector_fetch
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_ext,
  input  logic [TYPE_W-1:0] start_type,
  input  logic [TYPE_W-1:0] intr_data,
  input  logic              mem_rdy,
  input  logic [WORD_W-1:0] mem_data,
  output logic              inta,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic              busy,
  output logic [TYPE_W-1:0] svc_type,
  output logic [WORD_W-1:0] new_cs,
  output logic [WORD_W-1:0] new_ip
);
  fetch_st_t         st;
  logic [TYPE_W-1:0] cur_type;
  logic              capture_ev;
  logic              off_ev;
  logic              seg_ev;

  assign capture_ev = (st == ST_CAPT);
  assign off_ev     = (st == ST_RD_OFF) && mem_rdy;
  assign seg_ev     = (st == ST_RD_SEG) && mem_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_type <= '0;
      new_ip   <= '0;
      new_cs   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          cur_type <= start_type;
          st       <= start_ext ? ST_ACK : ST_RD_OFF;
        end
        ST_ACK:  st <= ST_CAPT;
        ST_CAPT: begin
          cur_type <= intr_data;
          st       <= ST_RD_OFF;
        end
        ST_RD_OFF: if (off_ev) begin
          new_ip <= mem_data;
          st     <= ST_RD_SEG;
        end
        ST_RD_SEG: if (seg_ev) begin
          new_cs <= mem_data;
          st     <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign inta     = (st == ST_ACK);
  assign mem_req  = (st == ST_RD_OFF) || (st == ST_RD_SEG);
  assign mem_addr = vec_byte_addr(cur_type, st == ST_RD_SEG);
  assign done     = (st == ST_DONE);
  assign busy     = (st != ST_IDLE);
  assign svc_type = cur_type;

  // R8: acknowledge is a single-cycle pulse
  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    inta |=> !inta);
  // R8: the type capture happens on the cycle right after the acknowledge
  a_r8_capture_after_ack: assert property (@(posedge clk) disable iff (rst)
    inta |=> capture_ev);
  // R10: request and address hold while waiting for ready
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));
  // R10: every table read stays inside the table
  a_r10_table_range: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr < 20'h00400));
  // R10: the segment read follows the offset read
  a_r10_order: assert property (@(posedge clk) disable iff (rst)
    off_ev |=> (mem_req && mem_addr[1]));
  // R11: done is one cycle and results stay put after it
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && $stable(new_cs) && $stable(new_ip) && $stable(svc_type)));
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NEXC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic [NEXC-1:0]   exc_req_i,
  input  logic              nmi_i,
  input  logic              swi_req_i,
  input  logic [7:0]        swi_type_i,
  input  logic              intr_i,
  input  logic [7:0]        intr_data_i,
  output logic              inta_o,
  input  logic              ie_wr_i,
  input  logic              ie_val_i,
  input  logic              tf_wr_i,
  input  logic              tf_val_i,
  output logic              ie_o,
  output logic              tf_o,
  output logic              mem_req_o,
  output logic [19:0]       mem_addr_o,
  input  logic              mem_rdy_i,
  input  logic [15:0]       mem_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [7:0]        svc_type_o,
  output logic [15:0]       new_cs_o,
  output logic [15:0]       new_ip_o,
  output logic [19:0]       fetch_addr_o
);
  irq_src_t          src;
  logic [TYPE_W-1:0] sel_type;
  logic              dbl_fault;
  logic              any_req;
  logic              accept;
  logic              internal_any;

  irq_arbiter #(.NEXC(NEXC)) u_arb (
    .exc_req  (exc_req_i),
    .trap_req (tf_o),
    .nmi      (nmi_i),
    .swi_req  (swi_req_i),
    .swi_type (swi_type_i),
    .intr     (intr_i),
    .ie       (ie_o),
    .src      (src),
    .sel_type (sel_type),
    .dbl_fault(dbl_fault),
    .any_req  (any_req)
  );

  assign accept       = boundary_i && !busy_o && any_req;
  assign internal_any = (|exc_req_i) || tf_o;

  irq_flags u_flags (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .ie_wr (ie_wr_i),
    .ie_val(ie_val_i),
    .tf_wr (tf_wr_i),
    .tf_val(tf_val_i),
    .ie    (ie_o),
    .tf    (tf_o)
  );

  irq_vector_fetch u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .start_ext (src == SRC_EXT),
    .start_type(sel_type),
    .intr_data (intr_data_i),
    .mem_rdy   (mem_rdy_i),
    .mem_data  (mem_data_i),
    .inta      (inta_o),
    .mem_req   (mem_req_o),
    .mem_addr  (mem_addr_o),
    .done      (done_o),
    .busy      (busy_o),
    .svc_type  (svc_type_o),
    .new_cs    (new_cs_o),
    .new_ip    (new_ip_o)
  );

  assign fetch_addr_o = phys_addr(new_cs_o, new_ip_o);

  // R9: a service starts only from a sampled boundary
  a_r9_start_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(boundary_i));
  // R3: simultaneous exceptions turn into the double-fault type
  a_r3_double_fault: assert property (@(posedge clk) disable iff (rst)
    (accept && dbl_fault) |=> (svc_type_o == 8'd8));
  // R4: non-maskable request maps to type 2 regardless of the enable flag
  a_r4_nmi_type: assert property (@(posedge clk) disable iff (rst)
    (accept && nmi_i && !internal_any) |=> (svc_type_o == 8'd2));
  // R1: an internal request always beats software and external sources
  a_r1_internal_first: assert property (@(posedge clk) disable iff (rst)
    (accept && internal_any) |=> !inta_o);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
  localparam int NEXC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary_i = 1'b0;
  logic [NEXC-1:0] exc_req_i = '0;
  logic nmi_i = 1'b0;
  logic swi_req_i = 1'b0;
  logic [7:0] swi_type_i = '0;
  logic intr_i = 1'b0;
  logic [7:0] intr_data_i = '0;
  logic inta_o;
  logic ie_wr_i = 1'b0, ie_val_i = 1'b0, tf_wr_i = 1'b0, tf_val_i = 1'b0;
  logic ie_o, tf_o;
  logic mem_req_o;
  logic [19:0] mem_addr_o;
  logic mem_rdy_i = 1'b0;
  logic [15:0] mem_data_i = '0;
  logic busy_o, done_o;
  logic [7:0] svc_type_o;
  logic [15:0] new_cs_o, new_ip_o;
  logic [19:0] fetch_addr_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int dly = 0;
  int cnt = 0;
  int nrd = 0;
  int a0 = 0, a1 = 0;
  int ext_type = 0;
  bit ack_seen = 1'b0;
  int ack_cycles = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NEXC(NEXC)) u0 (.*);

  function automatic int memf(int a);
    return (a * 40503 + 4660) & 65535;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder and acknowledge-type driver, away from the active edge
  always @(negedge clk) begin
    if (mem_rdy_i) begin
      mem_rdy_i = 1'b0;
      cnt = 0;
    end else if (mem_req_o) begin
      if (cnt >= dly) begin
        mem_rdy_i = 1'b1;
        mem_data_i = 16'(memf(int'(mem_addr_o)));
        if (nrd == 0) a0 = int'(mem_addr_o); else a1 = int'(mem_addr_o);
        nrd++;
      end else cnt++;
    end
    // correct type only in the cycle after the acknowledge, decoy otherwise
    intr_data_i = ack_seen ? 8'(ext_type) : 8'(ext_type ^ 8'h5A);
    ack_seen = inta_o;
    if (inta_o) ack_cycles++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic clear_reqs();
    exc_req_i = '0; nmi_i = 0; swi_req_i = 0; intr_i = 0;
  endtask

  task automatic write_flags(input bit ie, input bit tf);
    @(negedge clk);
    ie_wr_i = 1; ie_val_i = ie; tf_wr_i = 1; tf_val_i = tf;
    @(negedge clk);
    ie_wr_i = 0; tf_wr_i = 0;
  endtask

  // pulse a boundary with the current requests and follow the service
  task automatic serve(input int exp_t, input string req);
    int waited;
    int ecs, eip;
    nrd = 0; ack_cycles = 0;
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0; clear_reqs();
    chk(!ie_o && !tf_o, "R6 flags cleared", {ie_o, tf_o}, 0);
    waited = 0;
    while (!done_o && waited < 60) begin
      @(negedge clk); waited++;
    end
    eip = memf(4 * exp_t);
    ecs = memf(4 * exp_t + 2);
    chk(svc_type_o == 8'(exp_t), req, svc_type_o, exp_t);
    chk(a0 == 4 * exp_t && a1 == 4 * exp_t + 2, "R10 read order", a0, 4 * exp_t);
    chk(new_ip_o == 16'(eip) && new_cs_o == 16'(ecs), "R11 vector", {new_cs_o, new_ip_o}, ecs * 65536 + eip);
    chk(int'(fetch_addr_o) == ((ecs * 16 + eip) % 1048576), "R11 fetch address", fetch_addr_o, (ecs * 16 + eip) % 1048576);
    @(negedge clk);
    chk(!done_o && !busy_o && new_ip_o == 16'(eip) && new_cs_o == 16'(ecs), "R11 hold after done", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !inta_o && !mem_req_o && !ie_o && !tf_o, "R12 reset state",
        {busy_o, done_o, inta_o, mem_req_o, ie_o, tf_o}, 0);
    @(negedge clk); rst = 0;

    // R10 R11: every software type, varied read latency
    for (int t = 0; t < 256; t++) begin
      dly = t % 4;
      swi_req_i = 1; swi_type_i = 8'(t);
      serve(t, "R10 software type");
    end

    // R2 R3: single exceptions, then pairs
    dly = 1;
    for (int k = 0; k < NEXC; k++) begin
      exc_req_i = '0; exc_req_i[k] = 1'b1;
      serve(k, "R2 single exception");
    end
    for (int i = 0; i < NEXC; i++) begin
      for (int j = i + 1; j < NEXC; j += 3) begin
        exc_req_i = '0; exc_req_i[i] = 1'b1; exc_req_i[j] = 1'b1;
        serve(8, "R3 double fault");
      end
    end

    // R5: trap alone; R2: trap against each single exception
    write_flags(0, 1);
    serve(1, "R5 trap");
    for (int k = 0; k < NEXC; k++) begin
      write_flags(0, 1);
      exc_req_i = '0; exc_req_i[k] = 1'b1;
      serve(k < 1 ? k : 1, "R2 trap vs exception");
    end

    // R1: group order
    write_flags(1, 0);
    exc_req_i[6] = 1; nmi_i = 1; swi_req_i = 1; swi_type_i = 8'h77; intr_i = 1; ext_type = 8'h99;
    serve(6, "R1 internal first");
    write_flags(1, 0);
    nmi_i = 1; swi_req_i = 1; swi_type_i = 8'h77; intr_i = 1;
    serve(2, "R1 nmi second");
    write_flags(1, 0);
    swi_req_i = 1; swi_type_i = 8'h77; intr_i = 1;
    serve(8'h77, "R1 software third");

    // R4: nmi with enable clear
    write_flags(0, 0);
    nmi_i = 1;
    serve(2, "R4 nmi unmasked");

    // R8: external types with the handshake
    for (int t = 0; t < 256; t += 17) begin
      write_flags(1, 0);
      ext_type = t; intr_i = 1; dly = t % 3;
      serve(t, "R8 external type");
      chk(ack_cycles == 1, "R8 ack width", ack_cycles, 1);
    end

    // R7: external request while disabled
    write_flags(0, 0);
    ack_cycles = 0;
    intr_i = 1;
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && ack_cycles == 0, "R7 masked external", {busy_o, 8'(ack_cycles)}, 0);
    intr_i = 0;

    // R9: requests without a boundary
    swi_req_i = 1; swi_type_i = 8'h33;
    repeat (4) @(negedge clk);
    chk(!busy_o && !mem_req_o, "R9 no boundary", busy_o, 0);
    swi_req_i = 0;

    // R9: boundary while busy is ignored
    dly = 3; nrd = 0;
    swi_req_i = 1; swi_type_i = 8'h40;
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0; swi_type_i = 8'h41;
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0; swi_req_i = 0;
    for (int w = 0; w < 40 && !done_o; w++) @(negedge clk);
    chk(svc_type_o == 8'h40 && new_ip_o == 16'(memf(256)), "R9 busy boundary", svc_type_o, 8'h40);
    repeat (3) @(negedge clk);
    chk(!busy_o, "R9 no second service", busy_o, 0);

    // R12: reset mid-service
    swi_req_i = 1; swi_type_i = 8'h10;
    @(negedge clk); boundary_i = 1;
    @(negedge clk); boundary_i = 0; swi_req_i = 0; ie_wr_i = 1; ie_val_i = 1;
    @(negedge clk); ie_wr_i = 0; rst = 1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o && !ie_o && !tf_o && !done_o, "R12 reset clears", {busy_o, ie_o}, 0);
    rst = 0;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule